// File: doc/BRIEF.md
# Programmable Sensor Clock Synthesizer

This block derives a slow sampling clock for an on-die sensor array from the fast system clock. It does not use a single divide value. A 32-bit control word holds three 8-bit counts and an enable flag. One count sets the length of the low phase and one sets the length of the high phase. The third count sets how long a sample strobe stays asserted after each rising edge of the sensor clock. Software fills the word from a target ratio N as follows: key = N - 2, low = (key+1)>>1, high = key>>1 and hold = key>>1. The sensor clock then runs at the system clock frequency divided by key + 2, for ratios from 2:1 up to 512:1.

A small state machine has three states. PH_IDLE means the clock is parked low. PH_LOW and PH_HIGH are the two phases of the running clock. It moves through these transitions:

- PH_IDLE to PH_LOW, taken when the enable flag is sampled set. This loads the fields.
- PH_LOW to PH_HIGH, taken at the end of the low count while the enable flag is set.
- PH_LOW to PH_IDLE, taken at the end of the low count when the enable flag is clear.
- PH_HIGH to PH_LOW, taken at the end of the high count while the enable flag is set. This reloads the fields.
- PH_HIGH to PH_IDLE, taken at the end of the high count when the enable flag is clear.

The fields are reloaded only at the end of a full period. Because of this, a control word written at any moment never produces a shortened phase.

Top module: `sclk_synth`

## Requirements
- R1: While reset is asserted, and afterwards while the block is idle, both `sens_clk` and `smpl_strobe` are 0.
- R2: The control word fields are as follows: bits 7:0 hold the low count, bits 15:8 the high count, bits 23:16 the hold count, and bit 24 the enable flag (1 = run).
- R3: While running, the low phase lasts low+1 system cycles and the high phase lasts high+1 system cycles, so one period is low+high+2 cycles.
- R4: From idle, if the enable flag is first sampled at clock edge E, then `sens_clk` rises at edge E+low+1.
- R5: A new word written while running has no effect on the current period. Its fields first apply to the low phase that follows the current high phase.
- R6: If the enable flag is 0 at the last low cycle, no high phase follows and the block goes idle. If the flag is cleared during a high phase, that high phase completes in full and the block then goes idle.
- R7: `smpl_strobe` rises in the same cycle as `sens_clk` and stays high for hold+1 cycles. It restarts at every rising edge, may extend into the following low phase, and is cleared when the block goes idle.
- R8: With the key mapping, every ratio from 2 (low=0, high=0) to 512 (low=255, high=255) gives a period of key+2 cycles. Odd keys are included.
- R9: Control word bits 31:25 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Control word: low, high and hold counts plus the enable flag |
| sens_clk | output | 1 | Registered sensor sampling clock |
| smpl_strobe | output | 1 | Sample-data strobe aligned to each rising edge of `sens_clk` |

## Verification
The bench writes a new word in the middle of a low phase. A design that reloads at once would show a shortened low or high run, and the bench would see it. The bench clears the enable flag in a low phase, where a flawed block would emit one more high pulse. It also clears the flag in a high phase, where a flawed block would cut the pulse short. The bench runs both extreme ratios (2 and 512) and an odd key, which expose off-by-one errors in the phase counters. It also uses hold counts longer than the high phase and longer than the whole period; these catch a strobe that stops at the falling edge, reads the new hold value in the middle of a strobe, or fails to restart.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int SCLK_FW = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } sclk_phase_e;

    typedef struct packed {
        logic [SCLK_FW-1:0] hold;
        logic [SCLK_FW-1:0] hi;
        logic [SCLK_FW-1:0] lo;
    } sclk_cfg_t;

endpackage

// File: rtl/sclk_word_decode.sv
module sclk_word_decode
    import sclk_pkg::*;
#(
    parameter int CW_W     = 32,
    parameter int LO_POS   = 0,
    parameter int HI_POS   = 8,
    parameter int HOLD_POS = 16,
    parameter int EN_POS   = 24
) (
    input  logic [CW_W-1:0] cw,
    output sclk_cfg_t       cfg,
    output logic            en
);

    localparam int SPARE_LO = EN_POS + 1;

    // Field slices, positions fixed by the software contract (R2)
    assign cfg.lo   = cw[LO_POS   +: SCLK_FW];
    assign cfg.hi   = cw[HI_POS   +: SCLK_FW];
    assign cfg.hold = cw[HOLD_POS +: SCLK_FW];
    assign en       = cw[EN_POS];

    // Upper spare bits carry no meaning (R9)
    logic unused_spare;
    assign unused_spare = ^cw[CW_W-1:SPARE_LO];

endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
    import sclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sclk_cfg_t live_cfg,
    input  logic      live_en,
    output logic      sens_clk,
    output logic      go_high,
    output logic      to_idle,
    output logic      is_idle,
    output logic [SCLK_FW-1:0] hold_now
);

    sclk_phase_e        st, nxt;
    logic [SCLK_FW-1:0] cnt, cnt_nxt;
    sclk_cfg_t          cfg_q, cfg_nxt;
    logic               wrap;
    logic               sens_q;

    // Next-state logic
    always_comb begin
        nxt     = st;
        cnt_nxt = cnt + 1'b1;
        cfg_nxt = cfg_q;
        go_high = 1'b0;
        wrap    = 1'b0;
        unique case (st)
            PH_IDLE: begin
                cnt_nxt = '0;
                if (live_en) begin
                    nxt     = PH_LOW;
                    cfg_nxt = live_cfg;
                end
            end
            PH_LOW: begin
                if (cnt == cfg_q.lo) begin
                    cnt_nxt = '0;
                    if (live_en) begin
                        nxt     = PH_HIGH;
                        go_high = 1'b1;
                    end else begin
                        nxt = PH_IDLE;
                    end
                end
            end
            PH_HIGH: begin
                if (cnt == cfg_q.hi) begin
                    cnt_nxt = '0;
                    wrap    = 1'b1;
                    if (live_en) begin
                        nxt     = PH_LOW;
                        cfg_nxt = live_cfg;
                    end else begin
                        nxt = PH_IDLE;
                    end
                end
            end
            default: begin
                nxt     = PH_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= PH_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
        end else begin
            st    <= nxt;
            cnt   <= cnt_nxt;
            cfg_q <= cfg_nxt;
        end
    end

    // Output register: clock bit straight from a flop, no decode glitch
    always_ff @(posedge clk) begin
        if (!rst_n) sens_q <= 1'b0;
        else        sens_q <= (nxt == PH_HIGH);
    end

    assign sens_clk = sens_q;
    assign to_idle  = (nxt == PH_IDLE);
    assign is_idle  = (st == PH_IDLE);
    assign hold_now = cfg_q.hold;

    AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == PH_LOW) |-> (cnt <= cfg_q.lo)) and ((st == PH_HIGH) |-> (cnt <= cfg_q.hi)))
        else $error("phase counter overran its field"); // R3

    AST_HIGH_AFTER_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_HIGH && $past(st) != PH_HIGH) |->
            ($past(st) == PH_LOW && $past(cnt) == $past(cfg_q.lo)))
        else $error("high phase entered early"); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE && !wrap) |=> $stable(cfg_q))
        else $error("fields changed mid-period"); // R5

    AST_NO_EN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_LOW && cnt == cfg_q.lo && !live_en) |=> (st == PH_IDLE && !sens_clk))
        else $error("high phase issued without enable"); // R6

endmodule

// File: rtl/sclk_strobe_gen.sv
module sclk_strobe_gen
    import sclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               clear,
    input  logic [SCLK_FW-1:0] hold,
    output logic               strobe
);

    logic               on_q;
    logic [SCLK_FW-1:0] cnt_q;
    logic [SCLK_FW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (clear) begin
            on_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (load) begin
            on_q   <= 1'b1;
            cnt_q  <= '0;
            hold_q <= hold;
        end else if (on_q) begin
            if (cnt_q == hold_q) on_q <= 1'b0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    assign strobe = on_q;

    AST_STB_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        on_q |-> (cnt_q <= hold_q))
        else $error("strobe counter beyond hold"); // R7

    AST_STB_LOAD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (on_q && cnt_q == '0))
        else $error("strobe not restarted at rising edge"); // R7

endmodule

// File: rtl/sclk_synth.sv
module sclk_synth
    import sclk_pkg::*;
#(
    parameter int CW_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW_W-1:0] ctrl_word,
    output logic            sens_clk,
    output logic            smpl_strobe
);

    sclk_cfg_t          live_cfg;
    logic               live_en;
    logic               go_high;
    logic               to_idle;
    logic               is_idle;
    logic [SCLK_FW-1:0] hold_now;

    sclk_word_decode #(.CW_W(CW_W)) u_dec (
        .cw  (ctrl_word),
        .cfg (live_cfg),
        .en  (live_en)
    );

    sclk_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_cfg (live_cfg),
        .live_en  (live_en),
        .sens_clk (sens_clk),
        .go_high  (go_high),
        .to_idle  (to_idle),
        .is_idle  (is_idle),
        .hold_now (hold_now)
    );

    sclk_strobe_gen u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (go_high),
        .clear  (to_idle),
        .hold   (hold_now),
        .strobe (smpl_strobe)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> (!sens_clk && !smpl_strobe))
        else $error("activity while idle"); // R1

    AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sens_clk) |-> smpl_strobe)
        else $error("strobe missing at rising edge"); // R7

endmodule

// File: tb/tb_sclk_synth.sv
`timescale 1ns/1ps
module tb_sclk_synth;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cw;
    logic        sens_clk;
    logic        smpl_strobe;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    cmp_en = 0;
    string cur = "R1";

    always #2 clk = ~clk;

    sclk_synth dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_word   (cw),
        .sens_clk    (sens_clk),
        .smpl_strobe (smpl_strobe)
    );

    // Behavioural reference: remaining-cycle countdowns
    int m_mode = 0; // 0 idle, 1 low, 2 high
    int m_left = 0;
    int m_stb  = 0;
    int m_lo = 0, m_hi = 0, m_hold = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_stb = 0;
        end else begin
            if (m_stb > 0) m_stb--;
            case (m_mode)
                0: if (cw[24]) begin
                    m_lo = int'(cw[7:0]); m_hi = int'(cw[15:8]); m_hold = int'(cw[23:16]);
                    m_mode = 1; m_left = m_lo + 1;
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (cw[24]) begin m_mode = 2; m_left = m_hi + 1; m_stb = m_hold + 1; end
                        else m_mode = 0;
                    end
                end
                default: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (cw[24]) begin
                            m_lo = int'(cw[7:0]); m_hi = int'(cw[15:8]); m_hold = int'(cw[23:16]);
                            m_mode = 1; m_left = m_lo + 1;
                        end else m_mode = 0;
                    end
                end
            endcase
            if (m_mode == 0) m_stb = 0;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk(cur, "sens_clk vs model", int'(sens_clk), (m_mode == 2) ? 1 : 0);
            chk(cur, "smpl_strobe vs model", int'(smpl_strobe), (m_stb > 0) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] mk(bit en, int lo, int hi, int hold);
        logic [7:0] l8, h8, d8;
        l8 = lo[7:0]; h8 = hi[7:0]; d8 = hold[7:0];
        return {7'd0, en, d8, h8, l8};
    endfunction

    task automatic wait_rise();
        bit p;
        p = sens_clk;
        @(negedge clk);
        while (!(!p && sens_clk)) begin
            p = sens_clk;
            @(negedge clk);
        end
    endtask

    task automatic run_hi(output int n, output int s);
        n = 0; s = 0;
        while (sens_clk) begin
            n++;
            if (smpl_strobe) s++;
            @(negedge clk);
        end
    endtask

    task automatic run_lo(output int n);
        n = 0;
        while (!sens_clk) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic quiet_window(string req, int len);
        int act;
        act = 0;
        for (int i = 0; i < len; i++) begin
            if (sens_clk || smpl_strobe) act++;
            @(negedge clk);
        end
        chk(req, "active samples while stopped", act, 0);
    endtask

    initial begin
        int h, s, l, n;
        cw = 32'd0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "sens_clk in reset", int'(sens_clk), 0);
        chk("R1", "smpl_strobe in reset", int'(smpl_strobe), 0);
        rst_n = 1'b1;
        cmp_en = 1;
        @(negedge clk);
        chk("R1", "sens_clk idle after reset", int'(sens_clk), 0);

        // R4 start-up latency
        cur = "R4";
        cw = mk(1, 4, 1, 0);
        n = 0;
        while (!sens_clk) begin @(negedge clk); n++; end
        chk("R4", "samples to first rise", n, 6);

        // R2 / R3 field positions and phase lengths
        cur = "R3";
        cw = mk(1, 3, 5, 2);
        wait_rise(); wait_rise();
        run_hi(h, s); run_lo(l);
        chk("R2", "high run from bits 15:8", h, 6);
        chk("R2", "low run from bits 7:0", l, 4);
        chk("R2", "strobe from bits 23:16", s, 3);
        chk("R3", "period", h + l, 10);

        // R5 write during low phase
        cur = "R5";
        run_hi(h, s);
        cw = mk(1, 1, 1, 0);
        run_lo(l); chk("R5", "current low kept", l, 4);
        run_hi(h, s); chk("R5", "current high kept", h, 6);
        run_lo(l); chk("R5", "new low applied", l, 2);
        run_hi(h, s); chk("R5", "new high applied", h, 2);

        // R6 disable during low
        cur = "R6";
        cw = mk(1, 5, 3, 1);
        wait_rise(); wait_rise();
        run_hi(h, s);
        cw = 32'd0;
        quiet_window("R6", 40);
        // R6 disable during high
        cw = mk(1, 3, 5, 0);
        wait_rise();
        cw = 32'd0;
        run_hi(h, s);
        chk("R6", "high completes after disable", h, 6);
        quiet_window("R6", 30);

        // R8 ratio extremes and odd key
        cur = "R8";
        cw = mk(1, 0, 0, 0);
        wait_rise(); wait_rise();
        run_hi(h, s); run_lo(l);
        chk("R8", "ratio 2 period", h + l, 2);
        cw = mk(1, 255, 255, 255);
        wait_rise(); wait_rise();
        run_hi(h, s); run_lo(l);
        chk("R8", "ratio 512 period", h + l, 512);
        chk("R7", "ratio 512 strobe length", s, 256);
        cw = mk(1, 4, 3, 3);
        wait_rise(); wait_rise();
        run_hi(h, s); run_lo(l);
        chk("R8", "odd key 7 period", h + l, 9);

        // R9 spare bits
        cur = "R9";
        cw = mk(1, 2, 3, 1) | 32'hFE00_0000;
        wait_rise(); wait_rise();
        run_hi(h, s); run_lo(l);
        chk("R9", "high with spare bits set", h, 4);
        chk("R9", "low with spare bits set", l, 3);

        // R7 strobe longer than high phase
        cur = "R7";
        cw = mk(1, 5, 1, 4);
        wait_rise(); wait_rise();
        n = 0;
        while (smpl_strobe) begin n++; @(negedge clk); end
        chk("R7", "strobe spans into low", n, 5);
        // R7 strobe longer than period restarts each rise
        cw = mk(1, 1, 1, 10);
        wait_rise(); wait_rise();
        n = 0;
        for (int i = 0; i < 12; i++) begin
            if (smpl_strobe) n++;
            @(negedge clk);
        end
        chk("R7", "strobe held by restarts", n, 12);

        cur = "R6";
        cw = 32'd0;
        repeat (30) @(negedge clk);
        chk("R1", "idle again", int'(sens_clk), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule